// File: doc/BRIEF.md
# ADC Sample-and-Conversion Sequencer

This block is the digital control ahead of a 12-bit successive-approximation converter. It picks one of four clock-source tick streams and divides it by an integer from 1 to 8. The result is a conversion-clock enable, and every timing decision below counts in these conversion-clock cycles. It also selects one of four trigger lines, which it may invert, and synchronizes the result to that clock. From this it drives the sample window `sampcon`, a one-cycle conversion-start strobe and a busy flag. The analog converter is not part of the block. It is stood in for by a fixed 13-cycle conversion timer.

The sample window can be set in two ways. In trigger-width mode (`pulse_mode` = 0) the window stays open as long as the synchronized trigger is high. In timed mode (`pulse_mode` = 1) a sample timer holds the window open for a coded number of cycles. Four sequence modes set how many conversions one start produces and whether the run repeats. With `multi_conv` set in timed mode, each conversion after the first follows on by itself. With it clear, every conversion waits for a new trigger edge.

Top module: `adc_seq_ctl`

## Requirements
- R1: The conversion clock ticks once every `clk_div`+1 ticks of the source picked by `clk_sel`. The sample and conversion lengths below are counted in these ticks.
- R2: In timed mode the window lasts the number of conversion-clock cycles given by `samp_code`. Codes 0..12 map to 4, 8, 16, 32, 64, 96, 128, 192, 256, 384, 512, 768 and 1024. Codes 13..15 give 1024.
- R3: `conv_start` is high for exactly one `clk` cycle, in the cycle where `sampcon` falls. `busy` falls 13 conversion-clock cycles after a conversion starts when that conversion ends the run.
- R4: In trigger-width mode, with the conversion clock equal to `clk`, the window lasts exactly as many cycles as the trigger is high.
- R5: `trig_sel` picks the trigger line: 0 = `sw_start`, 1..3 = `tmr_trig[0]`..`tmr_trig[2]`. Edges on lines that are not selected have no effect.
- R6: When `trig_inv` = 1 the selected line is inverted, so a sample starts on that line's falling edge.
- R7: With `multi_conv` = 0, each conversion of a sequence needs its own trigger rising edge. `busy` stays high between the conversions of an unfinished sequence.
- R8: `seq_mode` encodes 0 = one conversion, 1 = a sequence of `seq_len`+1 conversions, 2 = repeated single, 3 = repeated sequence. In timed mode with `multi_conv` = 1 and `seq_mode` ≠ 0, one edge runs the whole sequence. The next sample opens in the cycle the previous conversion ends, so starts are spaced 13+N cycles apart.
- R9: Trigger edges that arrive during an automatic sequence are ignored. The number of conversions is unchanged.
- R10: In trigger-width mode `multi_conv` has no effect: one edge gives one conversion. Clearing `enable` while waiting for the next edge drops `busy`.
- R11: While `enable` = 0, no sample starts from idle.
- R12: Clearing `enable` during a conversion lets that conversion finish 13 cycles after its start. After that, no repeat follows.
- R13: During and after reset, `sampcon`, `conv_start` and `busy` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_src_tick | input | 4 | One-cycle tick per period of each clock source |
| clk_sel | input | 2 | Clock source select |
| clk_div | input | 3 | Divide ratio minus one |
| sw_start | input | 1 | Software start trigger |
| tmr_trig | input | 3 | Timer trigger lines |
| trig_sel | input | 2 | Trigger select |
| trig_inv | input | 1 | Invert selected trigger |
| pulse_mode | input | 1 | 1 = timed window, 0 = trigger-width window |
| samp_code | input | 4 | Sample length code |
| multi_conv | input | 1 | Auto-chain conversions |
| seq_mode | input | 2 | Sequence mode |
| seq_len | input | 4 | Conversions per sequence minus one |
| enable | input | 1 | Allows new samples to start |
| sampcon | output | 1 | Sample window |
| conv_start | output | 1 | Conversion start strobe |
| busy | output | 1 | Run in progress |

## Verification
Two events can fall in the same conversion-clock cycle. One is a trigger edge arriving while an automatic sequence reopens the sample window as the previous conversion ends. The other is `enable` being cleared while a repeated run reaches the end of a conversion. The bench fires extra trigger pulses all through a chained sequence and judges the result by the exact count and spacing of `conv_start` strobes. It also clears `enable` in the middle of a repeated conversion and checks that `busy` falls 13 cycles after the last start, with no further strobe.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SAMP = 2'd1,
    ST_CONV = 2'd2,
    ST_WAIT = 2'd3
  } seq_state_e;

  // sample window length in conversion-clock cycles for a 4-bit code
  function automatic int unsigned samp_ticks(input logic [3:0] code);
    int c;
    c = int'(code);
    if (c < 5)        return 32'd4 << c;
    else if (c >= 12) return 32'd1024;
    else if (code[0]) return 32'd3 << ((c + 5) / 2);
    else              return 32'd1 << ((c + 8) / 2);
  endfunction

endpackage

// File: rtl/adc_seq_clkdiv.sv
module adc_seq_clkdiv #(
  parameter int SEL_W = 2,
  parameter int DIV_W = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [(1<<SEL_W)-1:0]   src_tick,
  input  logic [SEL_W-1:0]        clk_sel,
  input  logic [DIV_W-1:0]        clk_div,
  output logic                    cclk_en
);

  logic             sel_tick;
  logic             terminal;
  logic [DIV_W-1:0] div_q, div_d;

  assign sel_tick = src_tick[clk_sel];
  assign terminal = (div_q >= clk_div);
  assign cclk_en  = sel_tick && terminal;

  always_comb begin
    div_d = div_q;
    if (sel_tick) div_d = terminal ? '0 : div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  // R1
  div_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cclk_en && clk_div != '0) |=> (!cclk_en || clk_div == '0));

endmodule

// File: rtl/adc_seq_trig.sv
module adc_seq_trig #(
  parameter int SEL_W = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cclk_en,
  input  logic [(1<<SEL_W)-1:0] trig_in,
  input  logic [SEL_W-1:0]      trig_sel,
  input  logic                  trig_inv,
  output logic                  shi_lvl,
  output logic                  shi_rise
);

  logic raw;
  logic sync_q, sync_d;
  logic prev_q, prev_d;

  assign raw = trig_in[trig_sel] ^ trig_inv;

  always_comb begin
    sync_d = sync_q;
    prev_d = prev_q;
    if (cclk_en) begin
      sync_d = raw;
      prev_d = sync_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign shi_lvl  = sync_q;
  assign shi_rise = sync_q & ~prev_q;

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int SEQ_W       = 4,
  parameter int CODE_W      = 4,
  parameter int CONV_CYCLES = 13,
  parameter int SCNT_W      = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cclk_en,
  input  logic              shi_lvl,
  input  logic              shi_rise,
  input  logic              enable,
  input  logic              pulse_mode,
  input  logic              multi_conv,
  input  logic [1:0]        seq_mode,
  input  logic [SEQ_W-1:0]  seq_len,
  input  logic [CODE_W-1:0] samp_code,
  output logic              sampcon,
  output logic              conv_start,
  output logic              busy
);

  localparam int CCNT_W = $clog2(CONV_CYCLES);
  localparam logic [CCNT_W-1:0] CONV_LD = CCNT_W'(CONV_CYCLES - 1);

  seq_state_e        state_q, state_d;
  logic [SCNT_W-1:0] stim_q, stim_d;
  logic [CCNT_W-1:0] ctim_q, ctim_d;
  logic [SEQ_W-1:0]  seq_q, seq_d;
  logic              cstart_q, cstart_d;

  logic [SCNT_W-1:0] samp_ld;
  logic              auto_go, seq_last, go_on, samp_end;

  assign samp_ld  = SCNT_W'(samp_ticks(4'(samp_code)) - 1);
  // seq_mode bit 0: multi-conversion sequence, bit 1: repeat
  assign auto_go  = pulse_mode && multi_conv && (seq_mode != 2'd0);
  assign seq_last = !seq_mode[0] || (seq_q == seq_len);
  assign go_on    = seq_last ? (seq_mode[1] && enable) : enable;
  assign samp_end = pulse_mode ? (stim_q == '0) : !shi_lvl;

  always_comb begin
    state_d  = state_q;
    stim_d   = stim_q;
    ctim_d   = ctim_q;
    seq_d    = seq_q;
    cstart_d = 1'b0;
    if (cclk_en) begin
      case (state_q)
        ST_IDLE: begin
          if (enable && shi_rise) begin
            state_d = ST_SAMP;
            stim_d  = samp_ld;
            seq_d   = '0;
          end
        end
        ST_WAIT: begin
          if (!enable) begin
            state_d = ST_IDLE;
          end else if (shi_rise) begin
            state_d = ST_SAMP;
            stim_d  = samp_ld;
          end
        end
        ST_SAMP: begin
          if (samp_end) begin
            state_d  = ST_CONV;
            ctim_d   = CONV_LD;
            cstart_d = 1'b1;
          end else if (pulse_mode) begin
            stim_d = stim_q - 1'b1;
          end
        end
        default: begin
          if (ctim_q != '0) begin
            ctim_d = ctim_q - 1'b1;
          end else begin
            seq_d = seq_last ? '0 : seq_q + 1'b1;
            if (go_on) begin
              state_d = auto_go ? ST_SAMP : ST_WAIT;
              stim_d  = samp_ld;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      stim_q   <= '0;
      ctim_q   <= '0;
      seq_q    <= '0;
      cstart_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      stim_q   <= stim_d;
      ctim_q   <= ctim_d;
      seq_q    <= seq_d;
      cstart_q <= cstart_d;
    end
  end

  assign sampcon    = (state_q == ST_SAMP);
  assign busy       = (state_q != ST_IDLE);
  assign conv_start = cstart_q;

  // R3
  fall_starts_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sampcon) |-> conv_start);

  // R3
  start_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  // R7
  start_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> (busy && !sampcon));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !enable) |=> !sampcon);

endmodule

// File: rtl/adc_seq_ctl.sv
module adc_seq_ctl #(
  parameter int SEL_W       = 2,
  parameter int DIV_W       = 3,
  parameter int CODE_W      = 4,
  parameter int SEQ_W       = 4,
  parameter int CONV_CYCLES = 13,
  parameter int SCNT_W      = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [(1<<SEL_W)-1:0] clk_src_tick,
  input  logic [SEL_W-1:0]      clk_sel,
  input  logic [DIV_W-1:0]      clk_div,
  input  logic                  sw_start,
  input  logic [(1<<SEL_W)-2:0] tmr_trig,
  input  logic [SEL_W-1:0]      trig_sel,
  input  logic                  trig_inv,
  input  logic                  pulse_mode,
  input  logic [CODE_W-1:0]     samp_code,
  input  logic                  multi_conv,
  input  logic [1:0]            seq_mode,
  input  logic [SEQ_W-1:0]      seq_len,
  input  logic                  enable,
  output logic                  sampcon,
  output logic                  conv_start,
  output logic                  busy
);

  logic [1:0] rsync_q;
  logic       rst_int_n;
  logic       cclk_en;
  logic       shi_lvl, shi_rise;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  adc_seq_clkdiv #(.SEL_W(SEL_W), .DIV_W(DIV_W)) u_clkdiv (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .src_tick (clk_src_tick),
    .clk_sel  (clk_sel),
    .clk_div  (clk_div),
    .cclk_en  (cclk_en)
  );

  adc_seq_trig #(.SEL_W(SEL_W)) u_trig (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .cclk_en  (cclk_en),
    .trig_in  ({tmr_trig, sw_start}),
    .trig_sel (trig_sel),
    .trig_inv (trig_inv),
    .shi_lvl  (shi_lvl),
    .shi_rise (shi_rise)
  );

  adc_seq_fsm #(
    .SEQ_W       (SEQ_W),
    .CODE_W      (CODE_W),
    .CONV_CYCLES (CONV_CYCLES),
    .SCNT_W      (SCNT_W)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .cclk_en    (cclk_en),
    .shi_lvl    (shi_lvl),
    .shi_rise   (shi_rise),
    .enable     (enable),
    .pulse_mode (pulse_mode),
    .multi_conv (multi_conv),
    .seq_mode   (seq_mode),
    .seq_len    (seq_len),
    .samp_code  (samp_code),
    .sampcon    (sampcon),
    .conv_start (conv_start),
    .busy       (busy)
  );

endmodule

// File: tb/adc_seq_ctl_tb_top.sv
`timescale 1ns/1ps
module adc_seq_ctl_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] src_tick;
  logic [1:0] clk_sel;
  logic [2:0] clk_div;
  logic [3:0] trig;
  logic [1:0] trig_sel;
  logic       trig_inv, pulse_mode, multi_conv, enable;
  logic [3:0] samp_code, seq_len;
  logic [1:0] seq_mode;
  logic       sampcon, conv_start, busy;

  int n_chk = 0, n_fail = 0;
  int cyc = 0, samp_run = 0, last_width = 0, n_start = 0, n_samp = 0;
  int last_start_cyc = 0, last_gap = 0, busy_fall_cyc = 0;
  bit prev_samp = 0, prev_busy = 0;
  int tcnt [4];

  always #4 clk = ~clk;

  adc_seq_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .clk_src_tick(src_tick), .clk_sel(clk_sel),
    .clk_div(clk_div), .sw_start(trig[0]), .tmr_trig(trig[3:1]),
    .trig_sel(trig_sel), .trig_inv(trig_inv), .pulse_mode(pulse_mode),
    .samp_code(samp_code), .multi_conv(multi_conv), .seq_mode(seq_mode),
    .seq_len(seq_len), .enable(enable), .sampcon(sampcon),
    .conv_start(conv_start), .busy(busy)
  );

  // source k ticks once every k+1 cycles
  always @(negedge clk) begin
    for (int k = 0; k < 4; k++) begin
      src_tick[k] = (tcnt[k] == 0);
      tcnt[k] = (tcnt[k] >= k) ? 0 : tcnt[k] + 1;
    end
  end

  function automatic int exp_samp(input int code);
    case (code)
      0: return 4;    1: return 8;    2: return 16;   3: return 32;
      4: return 64;   5: return 96;   6: return 128;  7: return 192;
      8: return 256;  9: return 384;  10: return 512; 11: return 768;
      default: return 1024;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  // monitor, sampled 2 ns after the rising edge
  always begin
    @(posedge clk);
    #2;
    cyc++;
    if (sampcon) begin
      if (!prev_samp) n_samp++;
      samp_run++;
    end else if (prev_samp) begin
      last_width = samp_run;
      samp_run = 0;
      chk(conv_start == 1'b1, "R3 start at window end", int'(conv_start), 1);
    end
    if (conv_start) begin
      if (n_start > 0) last_gap = cyc - last_start_cyc;
      n_start++;
      last_start_cyc = cyc;
    end
    if (prev_busy && !busy) busy_fall_cyc = cyc;
    prev_samp = sampcon;
    prev_busy = busy;
    if (cyc >= 190000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      summary();
    end
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clr();
    n_start = 0; n_samp = 0; last_width = 0; last_gap = 0; busy_fall_cyc = 0;
  endtask

  task automatic fire(input int idx, input int w);
    trig[idx] = 1'b1;
    wt(w);
    trig[idx] = 1'b0;
  endtask

  task automatic wait_idle();
    int k;
    k = 0;
    wt(3);
    while (busy && k < 60000) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic cfg(input int src, input int dv, input bit pm, input int code,
                     input bit msc, input int mode, input int len);
    clk_sel = 2'(src); clk_div = 3'(dv); pulse_mode = pm; samp_code = 4'(code);
    multi_conv = msc; seq_mode = 2'(mode); seq_len = 4'(len);
  endtask

  initial begin
    int src, dv, code, tper, w, len, n;
    void'($urandom(32'h1A2B3C4D));
    for (int k = 0; k < 4; k++) tcnt[k] = 0;
    rst_n = 1'b0; trig = 4'b0; trig_sel = 2'd0; trig_inv = 1'b0; enable = 1'b1;
    cfg(0, 0, 1, 0, 0, 0, 0);
    wt(4);
    // R13
    chk(!sampcon && !conv_start && !busy, "R13 in reset", int'({sampcon, conv_start, busy}), 0);
    rst_n = 1'b1;
    wt(5);
    chk(!sampcon && !conv_start && !busy, "R13 after reset", int'({sampcon, conv_start, busy}), 0);

    // R1 R2 R3: random source, divider and code in timed single mode
    for (int it = 0; it < 6; it++) begin
      src = int'($urandom % 4); dv = int'($urandom % 8); code = int'($urandom % 8);
      tper = (dv + 1) * (src + 1);
      cfg(src, dv, 1, code, 0, 0, 0);
      clr();
      fire(0, 2 * tper + 2);
      wait_idle();
      chk(last_width == exp_samp(code) * tper, "R1/R2 window length", last_width, exp_samp(code) * tper);
      chk(busy_fall_cyc - last_start_cyc == 13 * tper, "R3 conversion length",
          busy_fall_cyc - last_start_cyc, 13 * tper);
      chk(n_start == 1, "R3 one start", n_start, 1);
    end
    // R2 corner codes
    foreach (code_list[i]) begin
      cfg(0, 0, 1, code_list[i], 0, 0, 0);
      clr();
      fire(0, 4);
      wait_idle();
      chk(last_width == exp_samp(code_list[i]), "R2 code corner", last_width, exp_samp(code_list[i]));
    end

    // R4: trigger-width windows
    for (int it = 0; it < 4; it++) begin
      w = 1 + int'($urandom % 20);
      cfg(0, 0, 0, 0, 0, 0, 0);
      clr();
      fire(0, w);
      wait_idle();
      chk(last_width == w, "R4 window follows trigger", last_width, w);
      chk(busy_fall_cyc - last_start_cyc == 13, "R4 conversion after window", busy_fall_cyc - last_start_cyc, 13);
    end

    // R5: only the selected line starts a sample
    cfg(0, 0, 1, 0, 0, 0, 0);
    trig_sel = 2'd2;
    clr();
    fire(1, 4); fire(3, 4); fire(0, 4);
    wt(10);
    chk(n_samp == 0 && !busy, "R5 unselected ignored", n_samp, 0);
    fire(2, 4);
    wait_idle();
    chk(n_start == 1, "R5 selected line starts", n_start, 1);

    // R6: inverted trigger starts on falling line
    trig_sel = 2'd3;
    enable = 1'b0; trig_inv = 1'b1; trig[3] = 1'b1;
    wt(6);
    enable = 1'b1;
    wt(6);
    clr();
    chk(!busy, "R6 high line inverted idle", int'(busy), 0);
    trig[3] = 1'b0;
    wt(5);
    chk(busy == 1'b1, "R6 falling line starts", int'(busy), 1);
    wait_idle();
    chk(n_start == 1, "R6 one conversion", n_start, 1);
    enable = 1'b0; trig_inv = 1'b0;
    wt(6);
    enable = 1'b1; trig_sel = 2'd0;

    // R7: one edge per conversion without chaining
    cfg(0, 0, 1, 0, 0, 1, 2);
    clr();
    for (int k = 1; k <= 3; k++) begin
      fire(0, 4);
      wt(40);
      chk(n_start == k, "R7 starts per edge", n_start, k);
      chk(busy == (k < 3), "R7 busy between conversions", int'(busy), int'(k < 3));
    end

    // R8: chained sequence, random length
    len = 1 + int'($urandom % 4); code = int'($urandom % 3); dv = int'($urandom % 4);
    cfg(0, dv, 1, code, 1, 1, len);
    clr();
    fire(0, 2 * (dv + 1) + 2);
    wait_idle();
    chk(n_start == len + 1, "R8 chained count", n_start, len + 1);
    chk(last_gap == (13 + exp_samp(code)) * (dv + 1), "R8 chained spacing",
        last_gap, (13 + exp_samp(code)) * (dv + 1));

    // R9: extra edges during an automatic sequence
    cfg(0, 0, 1, 3, 1, 1, 3);
    clr();
    fire(0, 4);
    for (int k = 0; k < 3; k++) begin
      wt(20);
      fire(0, 4);
    end
    wait_idle();
    chk(n_start == 4, "R9 extra edges ignored", n_start, 4);

    // R10: chaining bit ignored in trigger-width mode
    cfg(0, 0, 0, 0, 1, 1, 3);
    clr();
    fire(0, 5);
    wt(40);
    chk(n_start == 1 && busy, "R10 single conversion per edge", n_start, 1);
    enable = 1'b0;
    wt(5);
    chk(!busy, "R10 enable clear leaves wait", int'(busy), 0);
    enable = 1'b1;

    // R11: disabled, no sample
    cfg(0, 0, 1, 0, 0, 0, 0);
    enable = 1'b0;
    clr();
    fire(0, 4);
    wt(30);
    chk(n_samp == 0 && !busy, "R11 disabled no sample", n_samp, 0);
    enable = 1'b1;
    wt(4);

    // R12: clear enable inside a repeated conversion
    cfg(0, 0, 1, 0, 1, 2, 0);
    clr();
    fire(0, 4);
    n = 0;
    while (n_start < 3 && n < 1000) begin
      @(negedge clk);
      n++;
    end
    wt(3);
    enable = 1'b0;
    wait_idle();
    wt(60);
    chk(n_start == 3, "R12 repeat stops", n_start, 3);
    chk(busy_fall_cyc - last_start_cyc == 13, "R12 conversion completes",
        busy_fall_cyc - last_start_cyc, 13);
    enable = 1'b1;

    summary();
  end

  int code_list [3] = '{12, 14, 9};

endmodule